// File: doc/BRIEF.md
# Product-Term Cluster Steering Allocator

This block sits between the product-term array and the macrocells of one logic block. It receives sixteen clusters, and each cluster is a small group of product terms. It reduces each cluster to a single sum term. It then delivers that sum either to the cluster's own macrocell input or one step along an expansion chain. A static steering word supplies one bit per cluster.

The sixteen destinations form four interleaved chains with a stride of four. Each chain closes on itself, so a cluster at the top of a chain is steered back to the bottom. A cluster reaches only its selected destination, and every other destination sees logic zero from that cluster. A destination that receives a steered cluster ORs it with its own cluster when that cluster is not steered away. This lets a wide function be built from two clusters. The path is purely combinational, and each chain step adds one level of logic.

Top module: `pt_steer_alloc`

## Requirements
- R1: A cluster's sum is the OR of its PT_W product-term inputs. Product term j of cluster m is bit j of `pt_i[m]`.
- R2: When `steer_cfg_i[m]` is 0, cluster m's sum appears on `alloc_o[m]`.
- R3: When `steer_cfg_i[m]` is 1, cluster m's sum appears on `alloc_o[(m+4) mod 16]`.
- R4: Chains are the index sets {m : m mod 4 = k}. Steering from 12, 13, 14 and 15 wraps to 0, 1, 2 and 3 respectively.
- R5: A steered cluster contributes logic zero to its own output.
- R6: `alloc_o[m]` is the OR of cluster m (when not steered) and cluster (m-4) mod 16 (when that cluster is steered).
- R7: No cluster drives more than one output. The number of asserted outputs never exceeds the number of clusters with a nonzero sum.
- R8: With all product terms low, every output is low for any steering word.
- R9: Outputs follow the inputs combinationally, with no clock, state or latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pt_i | input | 16 x PT_W | Product-term inputs, grouped by cluster |
| steer_cfg_i | input | 16 | Per-cluster steering: 0 = own output, 1 = next chain member |
| alloc_o | output | 16 | Allocator outputs, one per macrocell |

## Verification
The wrap-around is tested exhaustively. For each of the four chains, every combination of both steering bits and both activity bits is applied to the top member and the bottom member. An allocator that adds four without a modulo would drop these clusters or send them to the wrong index. For each cluster on its own, the bench checks that exactly one output rises. A design that leaves the own path enabled while steering would light two outputs. The merge cases place a steered cluster on a live destination. An allocator that muxes instead of ORing would lose one of the two terms. Random vectors that change every cycle would expose any hidden register or latch.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
  localparam int unsigned DEF_NUM_MC = 16;
  localparam int unsigned DEF_STRIDE = 4;
  localparam int unsigned DEF_PT_W   = 5;

  // destination index one step ahead on the wrapping chain
  function automatic int unsigned chain_next(input int unsigned idx,
                                             input int unsigned stride,
                                             input int unsigned num);
    return (idx + stride) % num;
  endfunction

  // source index one step behind on the wrapping chain
  function automatic int unsigned chain_prev(input int unsigned idx,
                                             input int unsigned stride,
                                             input int unsigned num);
    return (idx + num - stride) % num;
  endfunction
endpackage

// File: rtl/pt_cluster_or.sv
module pt_cluster_or #(
  parameter int unsigned PT_W = 5
) (
  input  logic [PT_W-1:0] pt_i,
  output logic            sum_o
);
  assign sum_o = |pt_i;

  always_comb begin
    p_sum_tracks_terms_r1: assert (sum_o == (pt_i != '0))
      else $error("cluster sum disagrees with its terms");
  end
endmodule

// File: rtl/steer_demux.sv
module steer_demux (
  input  logic data_i,
  input  logic steer_i,
  output logic own_o,
  output logic fwd_o
);
  // unselected leg is grounded
  always_comb begin
    own_o = 1'b0;
    fwd_o = 1'b0;
    if (steer_i) fwd_o = data_i;
    else         own_o = data_i;
  end

  always_comb begin
    p_one_leg_r7: assert ($onehot0({own_o, fwd_o}))
      else $error("cluster drives both legs");
    p_ground_own_r5: assert (!steer_i || !own_o)
      else $error("steered cluster leaks to own output");
    p_ground_fwd_r2: assert (steer_i || !fwd_o)
      else $error("unsteered cluster leaks onto chain");
  end
endmodule

// File: rtl/dest_merge.sv
module dest_merge (
  input  logic own_i,
  input  logic chain_i,
  output logic out_o
);
  assign out_o = own_i | chain_i;

  always_comb begin
    p_out_has_source_r6: assert (!out_o || own_i || chain_i)
      else $error("output asserted with no source");
    p_cascade_r6: assert (!(own_i || chain_i) || out_o)
      else $error("source dropped at merge");
  end
endmodule

// File: rtl/pt_steer_alloc.sv
module pt_steer_alloc
  import alloc_pkg::*;
#(
  parameter int unsigned NUM_MC = DEF_NUM_MC,
  parameter int unsigned STRIDE = DEF_STRIDE,
  parameter int unsigned PT_W   = DEF_PT_W
) (
  input  logic [NUM_MC-1:0][PT_W-1:0] pt_i,
  input  logic [NUM_MC-1:0]           steer_cfg_i,
  output logic [NUM_MC-1:0]           alloc_o
);
  localparam int unsigned NUM_CHAINS = STRIDE;
  localparam int unsigned CHAIN_LEN  = NUM_MC / STRIDE;

  logic [NUM_MC-1:0] cluster_sum;
  logic [NUM_MC-1:0] own_leg;
  logic [NUM_MC-1:0] fwd_leg;

  for (genvar m = 0; m < NUM_MC; m++) begin : g_src
    pt_cluster_or #(.PT_W(PT_W)) u_or (
      .pt_i  (pt_i[m]),
      .sum_o (cluster_sum[m])
    );
    steer_demux u_demux (
      .data_i  (cluster_sum[m]),
      .steer_i (steer_cfg_i[m]),
      .own_o   (own_leg[m]),
      .fwd_o   (fwd_leg[m])
    );
  end

  for (genvar m = 0; m < NUM_MC; m++) begin : g_dst
    localparam int unsigned SRC = chain_prev(m, STRIDE, NUM_MC);
    dest_merge u_merge (
      .own_i   (own_leg[m]),
      .chain_i (fwd_leg[SRC]),
      .out_o   (alloc_o[m])
    );
  end

  // wrap hop: top of each chain lands on its bottom
  for (genvar k = 0; k < NUM_CHAINS; k++) begin : g_wrap_chk
    localparam int unsigned TOP = k + STRIDE * (CHAIN_LEN - 1);
    localparam int unsigned BOT = chain_next(TOP, STRIDE, NUM_MC);
    always_comb begin
      p_wrap_r4: assert (!(steer_cfg_i[TOP] && cluster_sum[TOP]) || alloc_o[BOT])
        else $error("wrap hop lost on chain %0d", k);
    end
  end

  always_comb begin
    p_no_dup_r7: assert ($countones(alloc_o) <= $countones(cluster_sum))
      else $error("more outputs than active clusters");
    p_zero_in_r8: assert ((pt_i != '0) || (alloc_o == '0))
      else $error("output without any product term");
  end
endmodule

// File: tb/pt_steer_alloc_bench.sv
`timescale 1ns/1ps
module pt_steer_alloc_bench;
  localparam int N    = 16;
  localparam int S    = 4;
  localparam int PT_W = 5;

  typedef struct {
    logic [N-1:0] exp;
    string        req;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0][PT_W-1:0] pt = '0;
  logic [N-1:0] cfg = '0;
  logic [N-1:0] alloc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  item_t sb_q[$];

  always #5 clk = ~clk;

  pt_steer_alloc #(.NUM_MC(N), .STRIDE(S), .PT_W(PT_W)) u_pt_steer_alloc (
    .pt_i        (pt),
    .steer_cfg_i (cfg),
    .alloc_o     (alloc)
  );

  function automatic logic [N-1:0] model(input logic [N-1:0][PT_W-1:0] p,
                                         input logic [N-1:0] c);
    logic [N-1:0] e = '0;
    for (int i = 0; i < N; i++) begin
      if (p[i] != '0) begin
        if (c[i]) e[(i + S) % N] = 1'b1;
        else      e[i] = 1'b1;
      end
    end
    return e;
  endfunction

  task automatic drive(input logic [N-1:0][PT_W-1:0] p, input logic [N-1:0] c,
                       input string req);
    item_t it;
    @(negedge clk);
    pt  = p;
    cfg = c;
    it.exp = model(p, c);
    it.req = req;
    sb_q.push_back(it);
  endtask

  // monitor: compares half a cycle after each drive
  always @(posedge clk) begin
    if (rst_ni && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (alloc !== it.exp) begin
        errors++;
        $display("FAIL %s: alloc=%h expected=%h (pt=%h cfg=%h)",
                 it.req, alloc, it.exp, pt, cfg);
      end
      if ($countones(it.exp) > 0 && $countones(alloc) > $countones(it.exp)) begin
        checks++;
        errors++;
        $display("FAIL R7: %0d outputs high, expected %0d",
                 $countones(alloc), $countones(it.exp));
      end
    end
  end

  initial begin
    logic [N-1:0][PT_W-1:0] p;
    logic [N-1:0] c;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;

    // R8: quiet inputs, any steering
    drive('0, '0, "R8");
    drive('0, '1, "R8");
    drive('0, 16'hA5C3, "R8");

    // R1 R2: one cluster, one term, own output
    for (int i = 0; i < N; i++) begin
      p = '0;
      p[i][i % PT_W] = 1'b1;
      drive(p, '0, "R2");
    end
    for (int j = 0; j < PT_W; j++) begin
      p = '0;
      p[7] = PT_W'(1) << j;
      drive(p, '0, "R1");
    end

    // R3 R5 R7: lone steered cluster, own output grounded
    for (int i = 0; i < N; i++) begin
      p = '0;
      p[i] = '1;
      c = '0;
      c[i] = 1'b1;
      drive(p, c, (i >= N - S) ? "R4" : "R3");
      drive(p, c | 16'h5A5A, "R5");
    end

    // R4 exhaustive wrap: top/bottom of each chain, all cfg x activity
    for (int k = 0; k < S; k++) begin
      for (int v = 0; v < 16; v++) begin
        p = '0;
        c = '0;
        p[k + N - S] = {PT_W{v[0]}};
        p[k]         = {PT_W{v[1]}};
        c[k + N - S] = v[2];
        c[k]         = v[3];
        drive(p, c, "R4");
      end
    end

    // R6: steered cluster merges with live own cluster
    for (int m = 0; m < N; m++) begin
      p = '0;
      c = '0;
      p[m][0] = 1'b1;
      p[(m + N - S) % N][PT_W-1] = 1'b1;
      c[(m + N - S) % N] = 1'b1;
      drive(p, c, "R6");
    end

    // R7 R9: random vectors, changing every cycle
    for (int r = 0; r < 400; r++) begin
      for (int i = 0; i < N; i++) p[i] = PT_W'($urandom & $urandom);
      c = N'($urandom);
      drive(p, c, (r % 2 == 0) ? "R9" : "R7");
    end

    wait (sb_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule